// File: doc/BRIEF.md
# Gated Two-Stage Card Clock Divider

This block derives the clock for a storage-card interface from a faster parent clock. The parent clock feeds two cascaded dividers. A power-of-two source stage divides by 1, 2, 4, 8 or 16. Its output is exposed as a one-cycle tick train, the intermediate high-speed clock. A final stage then divides that tick train by 2 or 4 to produce the card clock. The card clock is a level that is high for exactly half of the total ratio and low for the other half.

Software sets the block through one 32-bit control word, written with a single strobe. The word holds the two ratio codes and two stop bits: one gates the intermediate tick train and one stops the card clock. A new ratio or a stop request never cuts a period short. The running period always completes, and the block decides at the end of its low phase whether to start another period, go idle or fault. A code outside the legal ranges raises an error flag and parks the clock low.

The control FSM has four states:
- IDLE: stopped, output low.
- HIGH: first half of a period.
- LOW: second half of a period.
- FAULT: illegal code, output low.

Its transitions are:
- IDLE to HIGH (start): the word is legal and the output stop bit is clear.
- IDLE to FAULT (reject): the word is illegal.
- HIGH to LOW (half): the high half of the period has elapsed.
- LOW to HIGH (repeat): the period ends and the word is legal and not stopped.
- LOW to IDLE (park): the period ends and the output stop bit is set.
- LOW to FAULT (reject): the period ends and the word is illegal.
- FAULT to HIGH (recover): the word becomes legal and the output stop bit is clear.
- FAULT to IDLE (recover): the word becomes legal and the output stop bit is set.

Top module: `card_clk_divider`

## Requirements
- R1: While reset is asserted and after it is released with no write, `card_clk`, `hs_tick`, `div_active`, `clk_enabled` and `cfg_err` are all 0. Reset loads both stop bits set and both ratio codes 0.
- R2: The source code in control bits [4:2] selects a ratio of 2^code for codes 0 to 4 (1, 2, 4, 8, 16).
- R3: The final code in control bits [1:0] selects ratio 2 for code 0 and ratio 4 for code 1. While running, `card_clk` is high for (source ratio x final ratio)/2 parent cycles and then low for the same count.
- R4: A source code of 5 to 7 or a final code of 2 or 3 drives `cfg_err` high from the cycle after the write. No new period starts while the word is illegal, so `card_clk` stays low from the next period end.
- R5: Control bit 8 set stops the card clock. The period in progress completes its high and low halves. `card_clk` then stays low and `div_active` drops. Clearing the bit restarts the clock.
- R6: Control bit 9 set suppresses `hs_tick` from the cycle after the write. It has no effect on the card clock period.
- R7: While the divider runs and bit 9 is clear, `hs_tick` pulses once every source-ratio parent cycles. It is never high while `div_active` is low.
- R8: `clk_enabled` is 1 exactly when both bits 8 and 9 of the stored word are 0. It changes only in the cycle after a write.
- R9: A ratio written mid-period takes effect only at the start of the next period. The period in progress keeps its old ratio.
- R10: Control bits other than [9:8] and [4:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word: [9] tick stop, [8] clock stop, [4:2] source code, [1:0] final code |
| card_clk | output | 1 | Divided card clock level |
| hs_tick | output | 1 | Gated intermediate tick, one parent cycle wide |
| div_active | output | 1 | High while a period is in progress |
| clk_enabled | output | 1 | Both stop bits of the stored word are clear |
| cfg_err | output | 1 | Stored word holds an illegal ratio code |

## Verification
A control write and a period end can share one clock edge. The boundary decision on that edge must use the word stored before the write. The bench provokes this by writing new ratios, stop requests and illegal codes while the clock runs. It writes both in mid-high phase and around boundaries. It then counts the high and low samples of the current and the following period. The current period must show the old ratio, and only a period that starts after the write may show the new one. A stop request is judged the same way: the high half must complete and be followed by a full low half before the output parks.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    localparam int CFG_W        = 32;
    localparam int FIN_LSB      = 0;
    localparam int FIN_W        = 2;
    localparam int SRC_LSB      = 2;
    localparam int SRC_W        = 3;
    localparam int STOP_OUT_POS = 8;
    localparam int STOP_HS_POS  = 9;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HIGH  = 2'd1,
        ST_LOW   = 2'd2,
        ST_FAULT = 2'd3
    } phase_t;

    typedef struct packed {
        logic             stop_hs;
        logic             stop_out;
        logic [SRC_W-1:0] src_code;
        logic [FIN_W-1:0] fin_code;
    } div_cfg_t;

endpackage

// File: rtl/cdiv_cfg_reg.sv
module cdiv_cfg_reg
    import cdiv_pkg::*;
#(
    parameter int SRC_MAX_CODE = 4,
    parameter int FIN_MAX_CODE = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output div_cfg_t         cfg,
    output logic             cfg_bad,
    output logic             enabled
);

    localparam logic [CFG_W-1:0] USED_MASK =
        (CFG_W'(1) << STOP_HS_POS) | (CFG_W'(1) << STOP_OUT_POS) |
        (CFG_W'((1 << SRC_W) - 1) << SRC_LSB) |
        (CFG_W'((1 << FIN_W) - 1) << FIN_LSB);

    logic unused_wdata;
    assign unused_wdata = ^(wdata & ~USED_MASK);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.stop_hs  <= 1'b1;
            cfg.stop_out <= 1'b1;
            cfg.src_code <= '0;
            cfg.fin_code <= '0;
        end else if (wr) begin
            cfg.stop_hs  <= wdata[STOP_HS_POS];
            cfg.stop_out <= wdata[STOP_OUT_POS];
            cfg.src_code <= wdata[SRC_LSB +: SRC_W];
            cfg.fin_code <= wdata[FIN_LSB +: FIN_W];
        end
    end

    assign cfg_bad = (cfg.src_code > SRC_W'(SRC_MAX_CODE)) ||
                     (cfg.fin_code > FIN_W'(FIN_MAX_CODE));
    assign enabled = !cfg.stop_hs && !cfg.stop_out;

endmodule

// File: rtl/cdiv_src_stage.sv
module cdiv_src_stage #(
    parameter int CODE_W = 3,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);

    localparam int SPAN_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    // Terminal count is 2^code - 1.
    assign lim  = CNT_W'((SPAN_W'(1) << code) - SPAN_W'(1));
    assign tick = run && (cnt == lim);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/cdiv_phase_fsm.sv
module cdiv_phase_fsm
    import cdiv_pkg::*;
#(
    parameter int FIN_MAX_CODE = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [SRC_W-1:0] src_code,
    input  logic [FIN_W-1:0] fin_code,
    input  logic             stop_out,
    input  logic             cfg_bad,
    output logic [SRC_W-1:0] src_act,
    output logic             clk_lvl,
    output logic             active
);

    localparam int HC_W = (FIN_MAX_CODE > 0) ? FIN_MAX_CODE : 1;

    phase_t           state;
    phase_t           nxt;
    logic [FIN_W-1:0] fin_act;
    logic [HC_W-1:0]  hcnt;
    logic [HC_W-1:0]  half_lim;
    logic             half_done;
    logic             load;

    // Ticks per half period: 2^fin_act.
    assign half_lim  = HC_W'(((HC_W+1)'(1) << fin_act) - (HC_W+1)'(1));
    assign half_done = tick && (hcnt == half_lim);
    assign load      = (nxt == ST_HIGH) && (state != ST_HIGH);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (cfg_bad)        nxt = ST_FAULT;
                else if (!stop_out) nxt = ST_HIGH;
            end
            ST_HIGH: begin
                if (half_done)      nxt = ST_LOW;
            end
            ST_LOW: begin
                if (half_done) begin
                    if (cfg_bad)       nxt = ST_FAULT;
                    else if (stop_out) nxt = ST_IDLE;
                    else               nxt = ST_HIGH;
                end
            end
            ST_FAULT: begin
                if (!cfg_bad)       nxt = stop_out ? ST_IDLE : ST_HIGH;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_act <= '0;
            fin_act <= '0;
        end else if (load) begin
            src_act <= src_code;
            fin_act <= fin_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || load || !active) begin
            hcnt <= '0;
        end else if (half_done) begin
            hcnt <= '0;
        end else if (tick) begin
            hcnt <= hcnt + HC_W'(1);
        end
    end

    always_comb begin
        clk_lvl = 1'b0;
        active  = 1'b0;
        unique case (state)
            ST_HIGH: begin
                clk_lvl = 1'b1;
                active  = 1'b1;
            end
            ST_LOW: begin
                active  = 1'b1;
            end
            ST_IDLE, ST_FAULT: begin
                clk_lvl = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/card_clk_divider.sv
module card_clk_divider
    import cdiv_pkg::*;
#(
    parameter int SRC_MAX_CODE = 4,
    parameter int FIN_MAX_CODE = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    output logic        card_clk,
    output logic        hs_tick,
    output logic        div_active,
    output logic        clk_enabled,
    output logic        cfg_err
);

    localparam int PRE_W = (SRC_MAX_CODE > 0) ? SRC_MAX_CODE : 1;

    div_cfg_t         cfg_q;
    logic             cfg_bad;
    logic             tick_w;
    logic [SRC_W-1:0] src_act_w;
    logic             stop_out_q;

    cdiv_cfg_reg #(
        .SRC_MAX_CODE (SRC_MAX_CODE),
        .FIN_MAX_CODE (FIN_MAX_CODE)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .wdata   (cfg_wdata),
        .cfg     (cfg_q),
        .cfg_bad (cfg_bad),
        .enabled (clk_enabled)
    );

    cdiv_src_stage #(
        .CODE_W (SRC_W),
        .CNT_W  (PRE_W)
    ) u_src (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (div_active),
        .code  (src_act_w),
        .tick  (tick_w)
    );

    cdiv_phase_fsm #(
        .FIN_MAX_CODE (FIN_MAX_CODE)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_w),
        .src_code (cfg_q.src_code),
        .fin_code (cfg_q.fin_code),
        .stop_out (cfg_q.stop_out),
        .cfg_bad  (cfg_bad),
        .src_act  (src_act_w),
        .clk_lvl  (card_clk),
        .active   (div_active)
    );

    assign stop_out_q = cfg_q.stop_out;
    assign hs_tick    = tick_w && !cfg_q.stop_hs;
    assign cfg_err    = cfg_bad;

endmodule

// File: rtl/card_clk_divider_sva.sv
module card_clk_divider_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic       card_clk,
    input logic       hs_tick,
    input logic       div_active,
    input logic       clk_enabled,
    input logic       cfg_err,
    input logic       stop_out_q,
    input logic [2:0] src_act
);

    // R4: an illegal stored word never lets a low clock rise
    assert_err_keeps_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !card_clk) |=> !card_clk);

    // R4: the error flag moves only after a write
    assert_err_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_err) |-> $past(cfg_wr));

    // R5: a stopped clock that is low stays low
    assert_stop_keeps_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_out_q && !card_clk) |=> !card_clk);

    // R7: no intermediate tick while the divider is idle
    assert_tick_needs_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hs_tick |-> div_active);

    // R8: the enable status moves only after a write
    assert_status_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_enabled) |-> $past(cfg_wr));

    // R9: the active source ratio changes only when a period starts
    assert_ratio_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(src_act) |-> $rose(card_clk));

endmodule

bind card_clk_divider card_clk_divider_sva u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .card_clk    (card_clk),
    .hs_tick     (hs_tick),
    .div_active  (div_active),
    .clk_enabled (clk_enabled),
    .cfg_err     (cfg_err),
    .stop_out_q  (stop_out_q),
    .src_act     (src_act_w)
);

// File: tb/card_clk_divider_bench.sv
module card_clk_divider_bench;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        card_clk;
    logic        hs_tick;
    logic        div_active;
    logic        clk_enabled;
    logic        cfg_err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    card_clk_divider u_card_clk_divider (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_wdata   (cfg_wdata),
        .card_clk    (card_clk),
        .hs_tick     (hs_tick),
        .div_active  (div_active),
        .clk_enabled (clk_enabled),
        .cfg_err     (cfg_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int s, input int f, input bit hs, input bit so);
        mk = (32'(s) << 2) | 32'(f) | (hs ? 32'h200 : 32'h0) | (so ? 32'h100 : 32'h0);
    endfunction

    function automatic int half_exp(input int s, input int f);
        half_exp = ((1 << s) * ((f == 1) ? 4 : 2)) / 2;
    endfunction

    task automatic wr(input logic [31:0] d);
        cfg_wdata = d;
        cfg_wr    = 1'b1;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic wait_rise();
        logic prev;
        int   g;
        prev = card_clk;
        g = 0;
        forever begin
            @(negedge clk);
            if (!prev && card_clk) break;
            prev = card_clk;
            g++;
            if (g > 400) break;
        end
    endtask

    task automatic count_hi(output int n);
        n = 0;
        while (card_clk && n < 200) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic count_lo(input int cap, output int n);
        n = 0;
        while (!card_clk && n < cap) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic measure(output int hi, output int lo);
        wait_rise();
        count_hi(hi);
        count_lo(200, lo);
    endtask

    task automatic count_ticks(input int win, output int n);
        n = 0;
        for (int i = 0; i < win; i++) begin
            if (hs_tick) n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int hi, lo, hi2, lo2, n, highs;
        void'($urandom(32'd20517));

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(card_clk == 0 && hs_tick == 0, "R1 clk/tick in reset", int'(card_clk), 0);
        chk(div_active == 0 && cfg_err == 0 && clk_enabled == 0, "R1 status in reset",
            int'({div_active, cfg_err, clk_enabled}), 0);
        rst_n = 1'b1;
        highs = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (card_clk || div_active || hs_tick) highs++;
        end
        chk(highs == 0 && clk_enabled == 0, "R1 stays stopped after reset", highs, 0);

        // R2 R3: every legal ratio pair
        for (int s = 0; s <= 4; s++) begin
            for (int f = 0; f <= 1; f++) begin
                wr(mk(s, f, s >= 2, 1'b0));
                measure(hi, lo);
                chk(hi == half_exp(s, f), $sformatf("R2 R3 high s=%0d f=%0d", s, f), hi, half_exp(s, f));
                chk(lo == half_exp(s, f), $sformatf("R3 low s=%0d f=%0d", s, f), lo, half_exp(s, f));
            end
        end

        // R8 R10: random legal words with junk in ignored bits
        for (int k = 0; k < 12; k++) begin
            int s, f;
            logic [31:0] w;
            s = int'($urandom_range(4, 0));
            f = int'($urandom_range(1, 0));
            w = mk(s, f, s >= 2, 1'b0) | ($urandom & 32'hFFFF_FCE0);
            wr(w);
            chk(clk_enabled == (s < 2), "R8 enable status", int'(clk_enabled), int'(s < 2));
            chk(cfg_err == 0, "R10 ignored bits raise no error", int'(cfg_err), 0);
            measure(hi, lo);
            chk(hi == half_exp(s, f) && lo == half_exp(s, f), "R10 R3 random period",
                hi + lo, 2 * half_exp(s, f));
        end

        // R9: ratio write during a high phase
        wr(mk(4, 1, 1'b1, 1'b0));
        wait_rise();
        hi = 0;
        while (card_clk && hi < 200) begin
            hi++;
            if (hi == 3) begin
                cfg_wdata = mk(0, 0, 1'b0, 1'b0);
                cfg_wr = 1'b1;
            end else begin
                cfg_wr = 1'b0;
            end
            @(negedge clk);
        end
        cfg_wr = 1'b0;
        count_lo(200, lo);
        count_hi(hi2);
        count_lo(200, lo2);
        chk(hi == 32 && lo == 32, "R9 old ratio kept", hi + lo, 64);
        chk(hi2 == 1 && lo2 == 1, "R9 new ratio next period", hi2 + lo2, 2);

        // R5: stop during high phase
        wr(mk(1, 1, 1'b0, 1'b0));
        wait_rise();
        hi = 0;
        while (card_clk && hi < 200) begin
            hi++;
            if (hi == 2) begin
                cfg_wdata = mk(1, 1, 1'b0, 1'b1);
                cfg_wr = 1'b1;
            end else begin
                cfg_wr = 1'b0;
            end
            @(negedge clk);
        end
        cfg_wr = 1'b0;
        count_lo(40, lo);
        chk(hi == 4, "R5 high half completes", hi, 4);
        chk(lo == 40, "R5 output parked low", lo, 40);
        chk(div_active == 0, "R5 inactive when parked", int'(div_active), 0);
        chk(clk_enabled == 0, "R8 status with clock stop", int'(clk_enabled), 0);
        wr(mk(1, 1, 1'b0, 1'b0));
        chk(clk_enabled == 1, "R8 status both clear", int'(clk_enabled), 1);
        measure(hi, lo);
        chk(hi == 4 && lo == 4, "R5 restart period", hi + lo, 8);

        // R4: illegal source code
        wr(mk(0, 1, 1'b0, 1'b0));
        wr(mk(6, 1, 1'b0, 1'b0));
        chk(cfg_err == 1, "R4 error on source code 6", int'(cfg_err), 1);
        repeat (10) @(negedge clk);
        highs = 0;
        n = 0;
        for (int i = 0; i < 30; i++) begin
            if (card_clk) highs++;
            if (hs_tick) n++;
            @(negedge clk);
        end
        chk(highs == 0 && div_active == 0, "R4 held low on bad source", highs, 0);
        chk(n == 0, "R4 no ticks while faulted", n, 0);
        wr(mk(0, 0, 1'b0, 1'b0));
        chk(cfg_err == 0, "R4 error clears", int'(cfg_err), 0);
        measure(hi, lo);
        chk(hi == 1 && lo == 1, "R4 recovery period", hi + lo, 2);
        wr(mk(0, 3, 1'b0, 1'b0));
        chk(cfg_err == 1, "R4 error on final code 3", int'(cfg_err), 1);
        repeat (6) @(negedge clk);
        highs = 0;
        for (int i = 0; i < 20; i++) begin
            if (card_clk) highs++;
            @(negedge clk);
        end
        chk(highs == 0, "R4 held low on bad final", highs, 0);
        wr(mk(7, 0, 1'b0, 1'b0));
        chk(cfg_err == 1, "R4 error on source code 7", int'(cfg_err), 1);

        // R7: tick rate per source ratio
        wr(mk(2, 0, 1'b0, 1'b0));
        wait_rise();
        count_ticks(64, n);
        chk(n == 16, "R7 ticks ratio 4", n, 16);
        wr(mk(0, 0, 1'b0, 1'b0));
        wait_rise();
        count_ticks(64, n);
        chk(n == 64, "R7 ticks ratio 1", n, 64);
        wr(mk(4, 0, 1'b0, 1'b0));
        wait_rise();
        count_ticks(64, n);
        chk(n == 4, "R7 ticks ratio 16", n, 4);

        // R6: tick stop leaves the card clock alone
        wr(mk(2, 1, 1'b0, 1'b0));
        wait_rise();
        wr(mk(2, 1, 1'b1, 1'b0));
        count_ticks(64, n);
        chk(n == 0, "R6 ticks suppressed", n, 0);
        measure(hi, lo);
        chk(hi == 8 && lo == 8, "R6 period unaffected", hi + lo, 16);
        chk(clk_enabled == 0, "R8 status with tick stop", int'(clk_enabled), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule